// File: doc/BRIEF.md
# Fracturable LUT Logic Cell

This block is a configurable logic cell with eight data inputs, two outputs and two flip-flops. One 64-bit truth-table store, split into two 32-bit halves, can act as a single 6-input lookup table, as two 5-input tables that share two inputs, as two independent 4-input tables that together take all eight inputs, or as a 7-input function. In the 7-input case each half computes a 5-input function over four shared inputs and one input of its own, and a further input selects between the two results with a 2:1 multiplexer.

Each half is built from 3-input table stages followed by a selector tree. Mode-controlled multiplexers in front of each half choose which data inputs drive which index bits. Every output can come straight from its table lane or from a flip-flop that samples that lane on each clock edge. A 68-bit configuration word is shifted in serially, one bit per clock while the load enable is high, and is held at all other times. The scan output lets chains of cells be loaded in series and read back.

Top module: `flut_cell`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge shifts `cfg_si` into configuration bit 0 and moves bit k to bit k+1. `cfg_so` always shows bit 67. Word layout: bits 31:0 are table half A, bits 63:32 are half B, bits 65:64 are the mode, bit 66 is the lane-0 bypass and bit 67 is the lane-1 bypass. A bypass bit of 1 selects the combinational lane.
- R2: While `cfg_en` is low, the configuration word does not change, whatever `cfg_si` does.
- R3: A rising clock edge with `rst` high clears both output flip-flops and the whole configuration word to zero.
- R4: Mode 00 (single 6-input table): lane 0 is table bit `din[5:0]` of the 64-bit store, with `din[5]` choosing the half. Lane 1 passes `din[7]` through, so that the free input can feed the lane-1 flip-flop.
- R5: Mode 01 (paired 5-input tables): lane 0 is half-A bit `din[4:0]`. Lane 1 is half-B bit `{din[7],din[6],din[5],din[1],din[0]}`, so `din[1:0]` are shared.
- R6: Mode 10 (independent 4-input tables): lane 0 is half-A bit `din[3:0]` and lane 1 is half-B bit `din[7:4]`. Store bits 31:16 and 63:48 have no effect on either output.
- R7: Mode 11 (7-input function): F1 is half-A bit `{din[6],din[3],din[2],din[1],din[0]}` and F2 is half-B bit `{din[6],din[3],din[5],din[1],din[0]}`. Lane 0 is F2 when `din[4]` is 1 and F1 otherwise. Lane 1 passes `din[7]` through.
- R8: With its bypass bit at 1, output `dout[i]` equals lane i in the same cycle. With its bypass bit at 0, `dout[i]` equals the value lane i had at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flip-flops and the configuration chain |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_si | input | 1 | Configuration serial data in |
| cfg_so | output | 1 | Configuration serial data out (word bit 67) |
| din | input | 8 | Logic inputs |
| dout | output | 2 | Logic outputs, lane 0 and lane 1 |

## Verification
The clocked properties assume that `rst` is high from time zero until at least one rising edge, so every flip-flop and every `$past` term holds a defined value before a check is enabled. They also assume that `din`, `cfg_en` and `cfg_si` are never unknown at a clock edge. The stimulus therefore holds reset from the first instant and drives every input only on falling clock edges. The same stimulus never changes inputs near a rising edge, so registered and bypassed outputs can both be compared at a fixed point in the cycle.

// File: rtl/flut_pkg.sv
package flut_pkg;

    // Operating modes held in configuration bits 65:64
    typedef enum logic [1:0] {
        MODE_LUT6  = 2'b00,
        MODE_DUAL5 = 2'b01,
        MODE_DUAL4 = 2'b10,
        MODE_EXT7  = 2'b11
    } flut_mode_e;

    // Number of output lanes, each with one flip-flop
    localparam int FLUT_LANES = 2;

    // Register state of the output stage
    typedef struct packed {
        logic [FLUT_LANES-1:0] cap;
    } flut_regs_t;

endpackage

// File: rtl/flut_cfg_chain.sv
module flut_cfg_chain #(
    parameter int CFG_W = 68
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_si,
    output logic [CFG_W-1:0] cfg_q,
    output logic             cfg_so
);

    logic [CFG_W-1:0] chain_d;
    logic [CFG_W-1:0] chain_q;

    always_comb begin
        chain_d = chain_q;
        if (cfg_en) begin
            chain_d = {chain_q[CFG_W-2:0], cfg_si};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign cfg_q  = chain_q;
    assign cfg_so = chain_q[CFG_W-1];

    // R2: nothing moves while shifting is disabled
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_so) && $stable(cfg_q));

    // R1: scan output advances by one position per enabled edge
    p_scan_step_r1: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> cfg_so == $past(cfg_q[CFG_W-2]) && cfg_q[0] == $past(cfg_si));

    // R3: reset wipes the configuration word
    p_cfg_clear_r3: assert property (@(posedge clk)
        rst |=> cfg_q == '0);

endmodule

// File: rtl/flut_half.sv
module flut_half #(
    parameter int IDX_W   = 5,
    parameter int STAGE_W = 3
) (
    input  logic [(1<<IDX_W)-1:0] mask,
    input  logic [IDX_W-1:0]      idx,
    output logic                  y
);

    localparam int STAGE_BITS = 1 << STAGE_W;
    localparam int NUM_STAGES = 1 << (IDX_W - STAGE_W);

    logic [NUM_STAGES-1:0] stage_y;

    // First level: small 3-input table stages sharing the low index bits
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        logic [STAGE_BITS-1:0] seg;
        assign seg        = mask[s*STAGE_BITS +: STAGE_BITS];
        assign stage_y[s] = seg[idx[STAGE_W-1:0]];
    end

    // Second level: selector tree over the stage results
    assign y = stage_y[idx[IDX_W-1:STAGE_W]];

endmodule

// File: rtl/flut_lut_core.sv
module flut_lut_core
    import flut_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int STAGE_W = 3
) (
    input  logic [(2<<IDX_W)-1:0] mask,
    input  flut_mode_e            mode,
    input  logic [7:0]            din,
    output logic [1:0]            lane_c,
    output logic                  half_a_y,
    output logic                  half_b_y
);

    localparam int HALF_BITS = 1 << IDX_W;

    logic [IDX_W-1:0] idx_a;
    logic [IDX_W-1:0] idx_b;

    // Mode-controlled swap multiplexers in front of each half
    always_comb begin
        idx_a = din[IDX_W-1:0];
        idx_b = din[IDX_W-1:0];
        case (mode)
            MODE_LUT6: begin
                idx_a = din[4:0];
                idx_b = din[4:0];
            end
            MODE_DUAL5: begin
                idx_a = din[4:0];
                idx_b = {din[7], din[6], din[5], din[1], din[0]};
            end
            MODE_DUAL4: begin
                idx_a = {1'b0, din[3:0]};
                idx_b = {1'b0, din[7:4]};
            end
            MODE_EXT7: begin
                idx_a = {din[6], din[3], din[2], din[1], din[0]};
                idx_b = {din[6], din[3], din[5], din[1], din[0]};
            end
            default: begin
                idx_a = din[4:0];
                idx_b = din[4:0];
            end
        endcase
    end

    flut_half #(
        .IDX_W  (IDX_W),
        .STAGE_W(STAGE_W)
    ) u_half_a (
        .mask(mask[HALF_BITS-1:0]),
        .idx (idx_a),
        .y   (half_a_y)
    );

    flut_half #(
        .IDX_W  (IDX_W),
        .STAGE_W(STAGE_W)
    ) u_half_b (
        .mask(mask[2*HALF_BITS-1:HALF_BITS]),
        .idx (idx_b),
        .y   (half_b_y)
    );

    // Output selection per mode
    always_comb begin
        lane_c = {half_b_y, half_a_y};
        case (mode)
            MODE_LUT6:  lane_c = {din[7], din[5] ? half_b_y : half_a_y};
            MODE_DUAL5: lane_c = {half_b_y, half_a_y};
            MODE_DUAL4: lane_c = {half_b_y, half_a_y};
            MODE_EXT7:  lane_c = {din[7], din[4] ? half_b_y : half_a_y};
            default:    lane_c = {half_b_y, half_a_y};
        endcase
    end

endmodule

// File: rtl/flut_out_stage.sv
module flut_out_stage
    import flut_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [FLUT_LANES-1:0] lane_c,
    input  logic [FLUT_LANES-1:0] bypass,
    output logic [FLUT_LANES-1:0] dout
);

    flut_regs_t regs_d;
    flut_regs_t regs_q;

    always_comb begin
        regs_d     = regs_q;
        regs_d.cap = lane_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar i = 0; i < FLUT_LANES; i++) begin : g_lane
        assign dout[i] = bypass[i] ? lane_c[i] : regs_q.cap[i];
    end

    // R3: flip-flops cleared by reset
    p_reg_clear_r3: assert property (@(posedge clk)
        rst |=> regs_q.cap == '0);

endmodule

// File: rtl/flut_cell.sv
module flut_cell
    import flut_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int STAGE_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_en,
    input  logic       cfg_si,
    output logic       cfg_so,
    input  logic [7:0] din,
    output logic [1:0] dout
);

    localparam int MASK_W   = 2 << IDX_W;
    localparam int MODE_LSB = MASK_W;
    localparam int BYP_LSB  = MASK_W + 2;
    localparam int CFG_W    = MASK_W + 2 + FLUT_LANES;

    logic [CFG_W-1:0]      cfg_q;
    logic [MASK_W-1:0]     mask;
    flut_mode_e            mode;
    logic [FLUT_LANES-1:0] bypass;
    logic [1:0]            lane_c;
    logic                  half_a_y;
    logic                  half_b_y;

    flut_cfg_chain #(
        .CFG_W(CFG_W)
    ) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .cfg_en(cfg_en),
        .cfg_si(cfg_si),
        .cfg_q (cfg_q),
        .cfg_so(cfg_so)
    );

    assign mask   = cfg_q[MASK_W-1:0];
    assign mode   = flut_mode_e'(cfg_q[MODE_LSB+1:MODE_LSB]);
    assign bypass = cfg_q[BYP_LSB+FLUT_LANES-1:BYP_LSB];

    flut_lut_core #(
        .IDX_W  (IDX_W),
        .STAGE_W(STAGE_W)
    ) u_core (
        .mask    (mask),
        .mode    (mode),
        .din     (din),
        .lane_c  (lane_c),
        .half_a_y(half_a_y),
        .half_b_y(half_b_y)
    );

    flut_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .lane_c(lane_c),
        .bypass(bypass),
        .dout  (dout)
    );

    // R4: the spare input reaches lane 1 in single-table mode
    p_lut6_spare_r4: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_LUT6 |-> lane_c[1] == din[7]);

    // R7: selector input picks between the two half results
    p_ext_low_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_EXT7 && !din[4]) |-> lane_c[0] == half_a_y);
    p_ext_high_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_EXT7 && din[4]) |-> lane_c[0] == half_b_y);

    // R8: bypassed output follows the lane, registered output lags one edge
    p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        bypass[0] |-> dout[0] == lane_c[0]);
    p_reg_path_r8: assert property (@(posedge clk) disable iff (rst)
        (!bypass[1] && !$past(rst)) |-> dout[1] == $past(lane_c[1]));

endmodule

// File: tb/flut_cell_tb.sv
module flut_cell_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CFG_W = 68;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_si = 1'b0;
    logic       cfg_so;
    logic [7:0] din = 8'h00;
    logic [1:0] dout;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flut_cell u_dut (
        .clk   (clk),
        .rst   (rst),
        .cfg_en(cfg_en),
        .cfg_si(cfg_si),
        .cfg_so(cfg_so),
        .din   (din),
        .dout  (dout)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (din=%0h)", req, act, exp, din);
        end
    endtask

    function automatic logic [CFG_W-1:0] mk_word(logic [63:0] m, logic [1:0] md, logic [1:0] byp);
        return {byp, md, m};
    endfunction

    // Behavioural model built from the requirement text
    function automatic logic [1:0] ref_out(logic [CFG_W-1:0] w, logic [7:0] d);
        logic [63:0] m;
        logic l0, l1, f1, f2;
        int ia, ib;
        m = w[63:0];
        l0 = 1'b0;
        l1 = 1'b0;
        case (w[65:64])
            2'b00: begin
                l0 = m[int'(d[5:0])];
                l1 = d[7];
            end
            2'b01: begin
                l0 = m[int'(d[4:0])];
                ib = 32 + int'({d[7], d[6], d[5], d[1], d[0]});
                l1 = m[ib];
            end
            2'b10: begin
                l0 = m[int'(d[3:0])];
                l1 = m[32 + int'(d[7:4])];
            end
            default: begin
                ia = int'({d[6], d[3], d[2], d[1], d[0]});
                ib = 32 + int'({d[6], d[3], d[5], d[1], d[0]});
                f1 = m[ia];
                f2 = m[ib];
                l0 = d[4] ? f2 : f1;
                l1 = d[7];
            end
        endcase
        return {l1, l0};
    endfunction

    task automatic load_cfg(logic [CFG_W-1:0] w);
        for (int i = CFG_W-1; i >= 0; i--) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_si = w[i];
        end
        @(negedge clk);
        cfg_en = 1'b0;
        cfg_si = 1'b0;
    endtask

    // Sweep all input values with both lanes bypassed
    task automatic sweep_comb(logic [CFG_W-1:0] w, string req);
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            din = 8'(v);
            #1;
            chk(req, {6'b0, dout}, {6'b0, ref_out(w, 8'(v))});
        end
    endtask

    task automatic test_reset_state;
        din = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R3 dout in reset", {6'b0, dout}, 8'h00);
        chk("R3 cfg_so in reset", {7'b0, cfg_so}, 8'h00);
        rst = 1'b0;
    endtask

    task automatic test_mode(logic [1:0] md, string req);
        for (int rep = 0; rep < 2; rep++) begin
            logic [CFG_W-1:0] w;
            w = mk_word({$urandom, $urandom}, md, 2'b11);
            load_cfg(w);
            sweep_comb(w, req);
        end
    endtask

    task automatic test_dual4_unused;
        logic [63:0] m;
        logic [CFG_W-1:0] w1, w2;
        logic [1:0] seen [256];
        m = {$urandom, $urandom};
        w1 = mk_word(m, 2'b10, 2'b11);
        load_cfg(w1);
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            din = 8'(v);
            #1;
            seen[v] = dout;
        end
        m = m ^ 64'hFFFF_0000_FFFF_0000;
        w2 = mk_word(m, 2'b10, 2'b11);
        load_cfg(w2);
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            din = 8'(v);
            #1;
            chk("R6 upper mask ignored", {6'b0, dout}, {6'b0, seen[v]});
        end
    endtask

    // Lane 1 bypassed, lane 0 registered
    task automatic test_registered(logic [1:0] md);
        logic [CFG_W-1:0] w;
        logic [7:0] prev;
        logic [1:0] rc, rp;
        w = mk_word({$urandom, $urandom}, md, 2'b10);
        load_cfg(w);
        @(negedge clk);
        din = 8'h00;
        prev = 8'h00;
        for (int v = 1; v < 256; v++) begin
            @(negedge clk);
            din = 8'(v);
            #1;
            rc = ref_out(w, 8'(v));
            rp = ref_out(w, prev);
            chk("R8 bypassed lane", {7'b0, dout[1]}, {7'b0, rc[1]});
            chk("R8 registered lane", {7'b0, dout[0]}, {7'b0, rp[0]});
            prev = 8'(v);
        end
    endtask

    task automatic test_scan_out;
        logic [CFG_W-1:0] w;
        w = mk_word({$urandom, $urandom}, 2'($urandom), 2'($urandom));
        load_cfg(w);
        for (int i = 0; i < CFG_W; i++) begin
            @(negedge clk);
            chk("R1 scan out", {7'b0, cfg_so}, {7'b0, w[CFG_W-1-i]});
            cfg_en = 1'b1;
            cfg_si = 1'b0;
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic test_hold;
        logic [CFG_W-1:0] w;
        w = mk_word({$urandom, $urandom}, 2'b01, 2'b11);
        load_cfg(w);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            cfg_en = 1'b0;
            cfg_si = 1'($urandom);
            chk("R2 hold scan out", {7'b0, cfg_so}, {7'b0, w[CFG_W-1]});
        end
        sweep_comb(w, "R2 hold function");
    endtask

    task automatic test_reset_clears;
        logic [CFG_W-1:0] w;
        w = mk_word(64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 2'b11);
        load_cfg(w);
        @(negedge clk);
        din = 8'hFF;
        #1;
        chk("R7 all-ones ext", {6'b0, dout}, 8'h03);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R3 outputs cleared", {6'b0, dout}, 8'h00);
        chk("R3 config cleared", {7'b0, cfg_so}, 8'h00);
        rst = 1'b0;
        din = 8'h80;
        @(negedge clk);
        chk("R3 zero config after reset", {6'b0, dout}, 8'h02);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        test_reset_state();
        test_mode(2'b00, "R4 single table");
        test_mode(2'b01, "R5 paired 5-input");
        test_mode(2'b10, "R6 independent 4-input");
        test_mode(2'b11, "R7 extended 7-input");
        test_dual4_unused();
        test_registered(2'b11);
        test_registered(2'b01);
        test_scan_out();
        test_hold();
        test_reset_clears();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule